// File: doc/BRIEF.md
# I2C master bit-timing generator

This block produces the SCL and SDA line timing for an I2C bus master, clocked from the system clock. It frames START and STOP conditions and clocks out or in single data bits. Every interval comes from a closed-form equation. Each equation has a base offset, plus a tap index less one times a tap spacing, and the result is scaled by a prescale multiplier of 1, 2 or 4. The block does not use one flat prescaler.

Both lines are open-drain. An asserted output enable pulls its line low. A released enable lets the line float high. After releasing SCL, the block waits until the SCL pad reads high before it counts the high half-period. After driving SCL low, it waits until the pad reads low before it ends the bit. A slave that stretches the clock, or another master that holds SCL low, therefore lengthens the period.

A controller issues one command at a time: START, data bit or STOP. It issues a command only while `ready` is high. The tap and multiplier settings are captured when a command is accepted.

Top module: `i2c_bit_timer`

## Requirements
- R1: During a data bit, `scl_oe` stays asserted for H clocks after the accepting edge and is then released. H = MUL × (SCL2TAP + (scl_tap − 1) × TAP2TAP + 2), which is half the SCL period. The defaults are SCL2TAP = 4 and TAP2TAP = 1.
- R2: The high half-period starts at the first edge that samples `scl_in` high. `scl_oe` is asserted again exactly H clocks after that edge. The bit ends on the first edge that then samples `scl_in` low.
- R3: During a data bit, `sda_oe` takes its new value exactly D clocks after the accepting edge. D = MUL × (SCL2TAP + (sda_tap − 1) × TAP2TAP + 3). `sda_oe` does not change while SCL is released within a bit.
- R4: START asserts `sda_oe` on the accepting edge and asserts `scl_oe` exactly S clocks later. S = MUL × (SCL2START + (scl_tap − 1) × TAP2TAP), with a default SCL2START of 2.
- R5: STOP asserts `sda_oe` on the accepting edge and releases SCL H clocks later. It releases `sda_oe` exactly P clocks after the first edge that samples `scl_in` high. P = MUL × (SCL2STOP + (scl_tap − 1) × TAP2TAP), with a default SCL2STOP of 7.
- R6: `mul_sel` selects the multiplier: 0 gives 1, 1 gives 2, and 2 or 3 gives 4.
- R7: While `scl_in` stays low after SCL is released, the high half-period does not start counting. A stretch of N clocks adds exactly N clocks to the high phase.
- R8: `bit_val` = 1 releases SDA and `bit_val` = 0 drives it low. `rx_bit` holds the `sda_in` value sampled on the edge that first sees `scl_in` high.
- R9: `ready` is high only while idle. It falls after the accepting edge. `done` is high for exactly one clock, set by the edge that ends a command. A strobe while `ready` is low is ignored.
- R10: If several strobes arrive together, START wins over STOP, and STOP wins over a data bit.
- R11: A synchronous reset releases both lines, clears the interval counter and returns the block to idle, even in the middle of a command.
- R12: The interval counter is wide enough for the largest tap setting (15) with a multiplier of 4, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_tap | input | TAP_W | SCL tap index, captured on accept |
| sda_tap | input | TAP_W | SDA hold tap index, captured on accept |
| mul_sel | input | 2 | Multiplier select (0:×1, 1:×2, 2/3:×4) |
| cmd_start | input | 1 | START command strobe |
| cmd_stop | input | 1 | STOP command strobe |
| cmd_bit | input | 1 | Data-bit command strobe |
| bit_val | input | 1 | Bit to send with `cmd_bit` (1 = release SDA) |
| scl_in | input | 1 | SCL level read back from the pad |
| sda_in | input | 1 | SDA level read back from the pad |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| ready | output | 1 | Idle, a command may be issued |
| done | output | 1 | One-clock pulse at the end of a command |
| rx_bit | output | 1 | SDA value sampled during the last data bit |

## Verification
The six lowest divider codes are tried at a multiplier of 1. These separate the SCL tap term from the SDA tap term, because pairs of codes share an SDA hold but differ in period. The same taps are then run at multipliers 2 and 4, and with select code 3, to check the scaling. The largest tap at ×4 checks that the counter does not wrap. Directed runs cover clock stretching by a slave, a slave pulling SDA during the read sample, a strobe while busy, simultaneous strobes, and a reset in the middle of a bit; each of these changes exactly one measured interval or line state.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_BLOW,
    ST_BWH,
    ST_BHIGH,
    ST_BWL,
    ST_PLOW,
    ST_PWH,
    ST_PHOLD
  } bt_state_t;

  // multiplier encoding: 0 -> 1, 1 -> 2, 2/3 -> 4
  function automatic int mul_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // (tap - 1) x spacing, with tap 0 treated as tap 1
  function automatic int tap_span(input int tap, input int spacing);
    return (tap > 0) ? (tap - 1) * spacing : 0;
  endfunction

  function automatic int half_period(input int m, input int scl_tap,
                                     input int s2t, input int t2t);
    return m * (s2t + tap_span(scl_tap, t2t) + 2);
  endfunction

  function automatic int sda_hold(input int m, input int sda_tap,
                                  input int s2t, input int t2t);
    return m * (s2t + tap_span(sda_tap, t2t) + 3);
  endfunction

  function automatic int edge_hold(input int m, input int scl_tap,
                                   input int base, input int t2t);
    return m * (base + tap_span(scl_tap, t2t));
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/i2c_bt_calc.sv
module i2c_bt_calc
  import i2c_bt_pkg::*;
#(
  parameter int TAP_W     = 4,
  parameter int CNT_W     = 7,
  parameter int SCL2TAP   = 4,
  parameter int SCL2START = 2,
  parameter int SCL2STOP  = 7,
  parameter int TAP2TAP   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TAP_W-1:0] scl_tap,
  input  logic [TAP_W-1:0] sda_tap,
  input  logic [1:0]       mul_sel,
  output logic [CNT_W-1:0] half_q,
  output logic [CNT_W-1:0] hold_q,
  output logic [CNT_W-1:0] st_q,
  output logic [CNT_W-1:0] sp_q
);

  int m_w, scl_w, sda_w;
  int half_w, hold_w, st_w, sp_w;

  always_comb begin
    m_w    = mul_of(mul_sel);
    scl_w  = int'(scl_tap);
    sda_w  = int'(sda_tap);
    half_w = at_least_one(half_period(m_w, scl_w, SCL2TAP, TAP2TAP));
    hold_w = at_least_one(sda_hold(m_w, sda_w, SCL2TAP, TAP2TAP));
    st_w   = at_least_one(edge_hold(m_w, scl_w, SCL2START, TAP2TAP));
    sp_w   = at_least_one(edge_hold(m_w, scl_w, SCL2STOP, TAP2TAP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '0;
      hold_q <= '0;
      st_q   <= '0;
      sp_q   <= '0;
    end else if (load) begin
      half_q <= CNT_W'(half_w);
      hold_q <= CNT_W'(hold_w);
      st_q   <= CNT_W'(st_w);
      sp_q   <= CNT_W'(sp_w);
    end
  end

endmodule

// File: rtl/i2c_bt_ctr.sv
module i2c_bt_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (clr) count <= '0;
    else if (run) count <= count + 1'b1;
  end

  // R12: a running interval never reaches the top code
  a_r12_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !clr) |-> (count != {W{1'b1}}));

endmodule

// File: rtl/i2c_bt_fsm.sv
module i2c_bt_fsm
  import i2c_bt_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_bit,
  input  logic             bit_val,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] half_q,
  input  logic [CNT_W-1:0] hold_q,
  input  logic [CNT_W-1:0] st_q,
  input  logic [CNT_W-1:0] sp_q,
  input  logic [CNT_W-1:0] elapsed,
  output logic             load,
  output logic             cnt_clr,
  output logic             cnt_run,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ready,
  output logic             done,
  output logic             rx_bit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bt_state_t state;
  logic      bit_q;

  // named internal events
  logic ev_accept, ev_pad_high, waiting;
  logic hit_half, hit_hold, hit_st, hit_sp;

  always_comb begin
    ready       = (state == ST_IDLE);
    ev_accept   = ready && (cmd_start || cmd_stop || cmd_bit);
    waiting     = (state == ST_BWH) || (state == ST_PWH) || (state == ST_BWL);
    ev_pad_high = ((state == ST_BWH) || (state == ST_PWH)) && scl_in;
    load        = ev_accept;
    cnt_clr     = ev_accept || ev_pad_high;
    cnt_run     = !ready && !waiting;
    hit_half    = (elapsed == half_q - ONE);
    hit_hold    = (elapsed == hold_q - ONE);
    hit_st      = (elapsed == st_q - ONE);
    hit_sp      = (elapsed == sp_q - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rx_bit <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            sda_oe <= 1'b1;
            state  <= ST_START;
          end else if (cmd_stop) begin
            sda_oe <= 1'b1;
            state  <= ST_PLOW;
          end else if (cmd_bit) begin
            bit_q  <= bit_val;
            state  <= ST_BLOW;
          end
        end
        ST_START: if (hit_st) begin
          scl_oe <= 1'b1;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_BLOW: begin
          if (hit_hold) sda_oe <= ~bit_q;
          if (hit_half) begin
            scl_oe <= 1'b0;
            state  <= ST_BWH;
          end
        end
        ST_BWH: if (scl_in) begin
          rx_bit <= sda_in;
          state  <= ST_BHIGH;
        end
        ST_BHIGH: if (hit_half) begin
          scl_oe <= 1'b1;
          state  <= ST_BWL;
        end
        ST_BWL: if (!scl_in) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_PLOW: if (hit_half) begin
          scl_oe <= 1'b0;
          state  <= ST_PWH;
        end
        ST_PWH: if (scl_in) state <= ST_PHOLD;
        ST_PHOLD: if (hit_sp) begin
          sda_oe <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: data line is quiet while the clock is released within a bit
  a_r3_sda_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BHIGH && $past(state) == ST_BHIGH) |-> $stable(sda_oe));

  // R4: SDA stays low during the whole START hold
  a_r4_start_sda_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> sda_oe);

  // R7: while the pad is held low, the clock stays released
  a_r7_wait_pad: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_BWH || state == ST_PWH) && !scl_in) |=> !scl_oe);

  // R9: completion pulse lasts one clock
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: accepted command makes the block busy
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> !ready);

  // R11: reset releases both lines and returns to idle
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && ready));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int TAP_W     = 4,
  parameter int SCL2TAP   = 4,
  parameter int SCL2START = 2,
  parameter int SCL2STOP  = 7,
  parameter int TAP2TAP   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] scl_tap,
  input  logic [TAP_W-1:0] sda_tap,
  input  logic [1:0]       mul_sel,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_bit,
  input  logic             bit_val,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ready,
  output logic             done,
  output logic             rx_bit
);

  // bound on any interval at the largest multiplier and tap
  localparam int MAX_IV = 4 * (SCL2TAP + SCL2START + SCL2STOP
                               + ((1 << TAP_W) - 1) * TAP2TAP + 3);
  localparam int CNT_W  = $clog2(MAX_IV + 2);

  logic [CNT_W-1:0] half_q, hold_q, st_q, sp_q, elapsed;
  logic             load, cnt_clr, cnt_run;

  i2c_bt_calc #(
    .TAP_W(TAP_W), .CNT_W(CNT_W), .SCL2TAP(SCL2TAP),
    .SCL2START(SCL2START), .SCL2STOP(SCL2STOP), .TAP2TAP(TAP2TAP)
  ) u_calc (
    .clk(clk), .rst(rst), .load(load),
    .scl_tap(scl_tap), .sda_tap(sda_tap), .mul_sel(mul_sel),
    .half_q(half_q), .hold_q(hold_q), .st_q(st_q), .sp_q(sp_q)
  );

  i2c_bt_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(cnt_clr), .run(cnt_run), .count(elapsed)
  );

  i2c_bt_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_bit(cmd_bit),
    .bit_val(bit_val), .scl_in(scl_in), .sda_in(sda_in),
    .half_q(half_q), .hold_q(hold_q), .st_q(st_q), .sp_q(sp_q),
    .elapsed(elapsed), .load(load), .cnt_clr(cnt_clr), .cnt_run(cnt_run),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready), .done(done),
    .rx_bit(rx_bit)
  );

endmodule

// File: tb/test_i2c_bit_timer.sv
`timescale 1ns/1ps
module test_i2c_bit_timer;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic [3:0] scl_tap = 4'd5, sda_tap = 4'd1;
  logic [1:0] mul_sel = 2'd0;
  logic       cmd_start = 0, cmd_stop = 0, cmd_bit = 0, bit_val = 0;
  logic       slave_scl = 0, slave_sda = 0;
  logic       scl_oe, sda_oe, ready, done, rx_bit;
  wire        scl_in = !(scl_oe || slave_scl);
  wire        sda_in = !(sda_oe || slave_sda);

  i2c_bit_timer i_i2c_bit_timer (
    .clk(clk), .rst(rst), .scl_tap(scl_tap), .sda_tap(sda_tap),
    .mul_sel(mul_sel), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_bit(cmd_bit), .bit_val(bit_val), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready), .done(done),
    .rx_bit(rx_bit)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // fields: scl_tap, sda_tap, mul_sel, period, sda hold, start hold, stop hold
  localparam int NV = 10;
  localparam int VEC [NV][7] = '{
    '{ 5, 1, 0,  20,  7,  6, 11},
    '{ 6, 1, 0,  22,  7,  7, 12},
    '{ 7, 2, 0,  24,  8,  8, 13},
    '{ 8, 2, 0,  26,  8,  9, 14},
    '{ 9, 3, 0,  28,  9, 10, 15},
    '{10, 3, 0,  30,  9, 11, 16},
    '{ 7, 2, 1,  48, 16, 16, 26},
    '{ 5, 1, 2,  80, 28, 24, 44},
    '{ 5, 1, 3,  80, 28, 24, 44},
    '{15, 3, 2, 160, 36, 64, 84}
  };

  // counters filled by run_cmd
  int c_hold_seq;  // sda_oe=1 with scl_oe=0 (start/stop hold)
  int c_scl_lo;    // scl_oe=1
  int c_scl_rel;   // scl_oe=0
  int c_sda_drv;   // sda_oe=1
  int done_end, done_next;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic s, input logic p, input logic b,
                         input logic bv, input int glitch_at, input int stretch);
    int left;
    left = stretch + 1;
    slave_scl = (stretch > 0);
    @(negedge clk);
    cmd_start = s; cmd_stop = p; cmd_bit = b; bit_val = bv;
    @(posedge clk);
    #1;
    cmd_start = 0; cmd_stop = 0; cmd_bit = 0;
    c_hold_seq = 0; c_scl_lo = 0; c_scl_rel = 0; c_sda_drv = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ready) break;
      if (sda_oe && !scl_oe) c_hold_seq++;
      if (scl_oe) c_scl_lo++;
      else begin
        c_scl_rel++;
        if (slave_scl) begin
          left--;
          if (left == 0) slave_scl = 0;
        end
      end
      if (sda_oe) c_sda_drv++;
      cmd_start = (i == glitch_at);
    end
    cmd_start = 0;
    slave_scl = 0;
    done_end = int'(done);
    @(negedge clk);
    done_next = int'(done);
  endtask

  task automatic set_vec(input int v);
    scl_tap = 4'(VEC[v][0]);
    sda_tap = 4'(VEC[v][1]);
    mul_sel = 2'(VEC[v][2]);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int h;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset scl_oe", int'(scl_oe), 0);
    chk("R11 reset sda_oe", int'(sda_oe), 0);
    chk("R11 reset ready", int'(ready), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      h = VEC[v][3] / 2;
      set_vec(v);
      run_cmd(1, 0, 0, 0, -1, 0);
      chk("R4/R6 start hold", c_hold_seq, VEC[v][5]);
      slave_sda = v[0];
      run_cmd(0, 0, 1, 1, -1, 0);
      // low phase H plus one clock confirming the pad low (R1)
      chk("R1/R6 scl low", c_scl_lo, h + 1);
      chk("R2/R6 scl high", c_scl_rel, h + 1);
      chk("R3/R6 sda hold", c_sda_drv, VEC[v][4]);
      chk("R8 rx bit", int'(rx_bit), v[0] ? 0 : 1);
      chk("R9 done pulse", done_end * 2 + done_next, 2);
      slave_sda = 0;
      run_cmd(0, 1, 0, 0, -1, 0);
      // release edge plus P clocks counted from the pad-high edge (R5)
      chk("R5/R6 stop hold", c_hold_seq, VEC[v][6] + 1);
      chk("R5 lines idle", int'(scl_oe) * 2 + int'(sda_oe), 0);
    end

    // R7: clock stretch by 5 clocks
    set_vec(0);
    run_cmd(1, 0, 0, 0, -1, 0);
    run_cmd(0, 0, 1, 0, -1, 5);
    chk("R7 stretched high", c_scl_rel, 10 + 1 + 5);
    chk("R7 low unaffected", c_scl_lo, 10 + 1);
    run_cmd(0, 1, 0, 0, -1, 0);

    // R9: strobe while busy ignored
    run_cmd(1, 0, 0, 0, -1, 0);
    run_cmd(0, 0, 1, 1, 3, 0);
    chk("R9 busy strobe hold", c_sda_drv, 7);
    chk("R9 busy strobe high", c_scl_rel, 11);
    chk("R9 busy strobe sda", int'(sda_oe), 0);
    chk("R9 ready after", int'(ready), 1);
    run_cmd(0, 1, 0, 0, -1, 0);

    // R10: start wins over bit
    run_cmd(1, 0, 1, 1, -1, 0);
    chk("R10 start over bit", c_hold_seq, 6);
    chk("R10 lines after start", int'(scl_oe) * 2 + int'(sda_oe), 3);
    // R10: stop wins over bit
    run_cmd(0, 1, 1, 1, -1, 0);
    chk("R10 stop over bit", c_hold_seq, 12);
    chk("R10 lines after stop", int'(scl_oe) * 2 + int'(sda_oe), 0);

    // R11: reset in the middle of a bit
    run_cmd(1, 0, 0, 0, -1, 0);
    @(negedge clk);
    cmd_bit = 1; bit_val = 0;
    @(negedge clk);
    cmd_bit = 0;
    repeat (4) @(negedge clk);
    chk("R11 busy before reset", int'(ready), 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R11 mid reset scl_oe", int'(scl_oe), 0);
    chk("R11 mid reset sda_oe", int'(sda_oe), 0);
    chk("R11 mid reset ready", int'(ready), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule